// File: doc/BRIEF.md
# Masked-Compare Escalating Watchdog

This block is a watchdog timer that runs from a slow, always-on clock of roughly 32.768 kHz, so one tick lasts about 30.5 µs. While enabled, a free-running counter advances once per tick. The counter is compared with a programmed match value. Software can leave a chosen number of the counter's most-significant bits out of this compare, which shortens the period between matches to a power of two that software selects. Each match sets an interrupt flag that software can mask, and it also advances an escalation stage.

If software does not service the block, the third match resets the system. The timeout therefore equals two full periods of the masked counter plus the match value. When the low-power input is high, the first match resets the system. Software services the block with a kick command, which returns the escalation stage to zero, and then usually writes a new match value equal to (count + timeout) modulo the masked period.

All control and configuration writes are refused until a two-word key sequence opens the lock. The counter-reset command takes effect one tick late, so software issues it twice before it reads the count.

Top module: `lp_watchdog`

## Requirements
- R1: While enabled, the counter (read at address 5) increases by one on each clock. While disabled, it holds its value unless a counter reset is pending.
- R2: The ignore field (address 3) sets how many counter MSBs the compare skips. Only the low (16 - ignore) bits of the count and of the match value (address 2) are compared. Writes above 12 are stored as 12, so the low four bits are always compared.
- R3: A match event is a single-cycle event. It occurs in the first cycle in which the compared bits become equal, and not in later cycles while they stay equal.
- R4: In normal mode, with the counter at 0 when the enable write lands, sys_rst_o goes high for exactly one cycle. It rises 2*2^(16-ignore) + M + 1 clock edges after the enable edge, where M is the compared part of the match value and is nonzero.
- R5: With lowpwr_i high, the first match gives the one-cycle reset pulse M + 1 edges after the enable edge.
- R6: A kick (address 1, bit 2) returns the escalation stage to zero. Kicking more often than two masked periods never produces a reset, and stopping the kicks lets a reset follow.
- R7: The lock opens only after a write of 16'h3C96 to address 0 followed at once by a write of 16'hC369 to address 0. Any other write to address 0 closes the lock. Address 0 reads 1 in bit 0 when the lock is open. While the lock is closed, writes to addresses 1, 2 and 3 have no effect.
- R8: Each match sets the pending flag (read at address 4, bit 0). irq_o equals pending AND NOT mask. A write to address 4 clears pending when bit 0 is set and loads the mask from bit 1. This register is not lock-protected.
- R9: A counter reset (address 1, bit 3) clears the counter one edge after the write edge. A read taken just after the write still shows the old count plus one, and a read one cycle later shows 0.
- R10: Disabling (address 1, bit 1, which wins over bit 0 enable) holds the counter and returns the escalation stage to zero. After re-enabling, three fresh matches are needed before a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Slow watchdog clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lowpwr_i | input | 1 | Low-power mode; the first match resets the system |
| reg_we_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational from reg_addr_i |
| irq_o | output | 1 | Match interrupt after masking |
| sys_rst_o | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that every register write lasts exactly one clock, and that lowpwr_i and the register inputs are stable around each rising edge. The stimulus changes these inputs only on falling edges and drops the write strobe after one cycle. The assertions also assume that a kick and a match never coincide without the kick winning. The bench therefore never relies on timing in that cycle: it only checks windows in which the kick interval is shorter than the match spacing. Timeout measurements always start from a counter cleared by two reset commands and from a match value whose compared part is nonzero, so the counter never starts in the matching state.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_LOCK  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd1;
  localparam logic [ADDR_W-1:0] A_MATCH = 3'd2;
  localparam logic [ADDR_W-1:0] A_IGN   = 3'd3;
  localparam logic [ADDR_W-1:0] A_IRQ   = 3'd4;
  localparam logic [ADDR_W-1:0] A_CNT   = 3'd5;

  localparam int CB_EN   = 0;
  localparam int CB_DIS  = 1;
  localparam int CB_KICK = 2;
  localparam int CB_ZERO = 3;

  localparam int IB_CLR  = 0;
  localparam int IB_MASK = 1;

  localparam logic [DATA_W-1:0] KEY_FIRST  = 16'h3C96;
  localparam logic [DATA_W-1:0] KEY_SECOND = 16'hC369;

  typedef enum logic [1:0] {
    LK_SHUT = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lock_state_e;
endpackage

// File: rtl/wdt_lock.sv
module wdt_lock
  import wdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] key_i,
  output logic              open_o
);
  lock_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (wr_i) begin
      if (key_i == KEY_FIRST)                              state_d = LK_HALF;
      else if (key_i == KEY_SECOND && state_q == LK_HALF)  state_d = LK_OPEN;
      else                                                 state_d = LK_SHUT;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LK_SHUT;
    else         state_q <= state_d;
  end

  assign open_o = (state_q == LK_OPEN);

  // R7
  open_needs_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(wr_i && key_i == KEY_SECOND));

  // R7
  foreign_write_shuts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && key_i != KEY_FIRST && key_i != KEY_SECOND) |=> !open_o);
endmodule

// File: rtl/wdt_tick_cmp.sv
module wdt_tick_cmp #(
  parameter int CNT_W = 16,
  parameter int IGN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             zero_req_i,
  input  logic [IGN_W-1:0] ign_i,
  input  logic [CNT_W-1:0] match_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             zero_pend_q;
  logic             eq, eq_q;
  logic [CNT_W-1:0] cmp_mask;

  // counter reset lands one edge after the request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      zero_pend_q <= 1'b0;
    end else begin
      zero_pend_q <= zero_req_i;
      if (zero_pend_q) cnt_q <= '0;
      else if (run_i)  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cmp_mask = {CNT_W{1'b1}} >> ign_i;
  assign eq       = ((cnt_q ^ match_i) & cmp_mask) == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eq_q <= 1'b1;
    else         eq_q <= eq;
  end

  assign hit_o = run_i && eq && !eq_q;
  assign cnt_o = cnt_q;

  // R1
  held_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !zero_pend_q) |=> $stable(cnt_q));

  // R1
  step_when_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !zero_pend_q) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R3
  hit_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> !hit_o);

  // R9
  zero_late_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_req_i |=> ##1 cnt_q == '0);
endmodule

// File: rtl/wdt_escalate.sv
module wdt_escalate #(
  parameter int STAGES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic hit_i,
  input  logic lowpwr_i,
  input  logic kick_i,
  input  logic irq_clr_i,
  input  logic irq_mask_i,
  output logic sys_rst_o,
  output logic irq_pend_o,
  output logic irq_o
);
  localparam int ESC_W = $clog2(STAGES);
  localparam logic [ESC_W-1:0] LAST = ESC_W'(STAGES - 1);

  logic [ESC_W-1:0] esc_q;
  logic             fire;
  logic             rst_q, pend_q;

  assign fire = run_i && hit_i && !kick_i && (lowpwr_i || esc_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      esc_q <= '0;
      rst_q <= 1'b0;
    end else begin
      rst_q <= fire;
      if (!run_i || kick_i || fire) esc_q <= '0;
      else if (hit_i)               esc_q <= esc_q + 1'b1;
    end
  end

  // a new match wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pend_q <= 1'b0;
    else if (hit_i)     pend_q <= 1'b1;
    else if (irq_clr_i) pend_q <= 1'b0;
  end

  assign sys_rst_o  = rst_q;
  assign irq_pend_o = pend_q;
  assign irq_o      = pend_q && !irq_mask_i;

  // R4
  esc_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esc_q <= LAST);

  // R4
  rst_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> !sys_rst_o);

  // R5
  lowpwr_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && hit_i && lowpwr_i && !kick_i) |=> sys_rst_o);

  // R6
  kick_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> esc_q == '0);

  // R8
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !hit_i) |=> !irq_pend_o);

  // R10
  off_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> esc_q == '0 && !sys_rst_o);
endmodule

// File: rtl/lp_watchdog.sv
module lp_watchdog
  import wdt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MIN_CMP = 4,
  parameter int STAGES  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lowpwr_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              sys_rst_o
);
  localparam int MAX_IGN = CNT_W - MIN_CMP;
  localparam int IGN_W   = $clog2(MAX_IGN + 1);

  logic             open;
  logic             en_q, mask_q;
  logic [CNT_W-1:0] match_q, cnt;
  logic [IGN_W-1:0] ign_q;
  logic             hit, irq_pend;
  logic             wr_lock, wr_ctrl, wr_match, wr_ign, wr_irq;
  logic             kick, zero_req, irq_clr;

  assign wr_lock  = reg_we_i && reg_addr_i == A_LOCK;
  assign wr_ctrl  = reg_we_i && reg_addr_i == A_CTRL  && open;
  assign wr_match = reg_we_i && reg_addr_i == A_MATCH && open;
  assign wr_ign   = reg_we_i && reg_addr_i == A_IGN   && open;
  assign wr_irq   = reg_we_i && reg_addr_i == A_IRQ;

  assign kick     = wr_ctrl && reg_wdata_i[CB_KICK];
  assign zero_req = wr_ctrl && reg_wdata_i[CB_ZERO];
  assign irq_clr  = wr_irq  && reg_wdata_i[IB_CLR];

  wdt_lock i_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_lock),
    .key_i  (reg_wdata_i),
    .open_o (open)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      mask_q  <= 1'b0;
      match_q <= '0;
      ign_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        if (reg_wdata_i[CB_DIS])     en_q <= 1'b0;
        else if (reg_wdata_i[CB_EN]) en_q <= 1'b1;
      end
      if (wr_match) match_q <= reg_wdata_i[CNT_W-1:0];
      if (wr_ign) begin
        if (reg_wdata_i > DATA_W'(MAX_IGN)) ign_q <= IGN_W'(MAX_IGN);
        else                                ign_q <= reg_wdata_i[IGN_W-1:0];
      end
      if (wr_irq) mask_q <= reg_wdata_i[IB_MASK];
    end
  end

  wdt_tick_cmp #(.CNT_W(CNT_W), .IGN_W(IGN_W)) i_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (en_q),
    .zero_req_i (zero_req),
    .ign_i      (ign_q),
    .match_i    (match_q),
    .cnt_o      (cnt),
    .hit_o      (hit)
  );

  wdt_escalate #(.STAGES(STAGES)) i_esc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (en_q),
    .hit_i      (hit),
    .lowpwr_i   (lowpwr_i),
    .kick_i     (kick),
    .irq_clr_i  (irq_clr),
    .irq_mask_i (mask_q),
    .sys_rst_o  (sys_rst_o),
    .irq_pend_o (irq_pend),
    .irq_o      (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_LOCK:  reg_rdata_o[0] = open;
      A_CTRL:  reg_rdata_o[0] = en_q;
      A_MATCH: reg_rdata_o[CNT_W-1:0] = match_q;
      A_IGN:   reg_rdata_o[IGN_W-1:0] = ign_q;
      A_IRQ:   reg_rdata_o[1:0] = {mask_q, irq_pend};
      A_CNT:   reg_rdata_o[CNT_W-1:0] = cnt;
      default: reg_rdata_o = '0;
    endcase
  end

  // R7
  locked_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_CTRL && !open) |=> $stable(en_q));

  // R7
  locked_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_MATCH && !open) |=> $stable(match_q));

  // R2
  ign_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ign_q <= IGN_W'(MAX_IGN));
endmodule

// File: tb/test_lp_watchdog.sv
module test_lp_watchdog;
  import wdt_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int VEC_N = 6;
  // ignore, match, lowpwr, expected edges from enable to reset
  localparam int V_IGN [VEC_N] = '{12, 12,     11, 10,  12, 12};
  localparam int V_MAT [VEC_N] = '{5,  'hF305, 3,  40,  9,  15};
  localparam int V_LP  [VEC_N] = '{0,  0,      0,  0,   1,  1};
  localparam int V_EXP [VEC_N] = '{38, 38,     68, 169, 10, 16};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              lowpwr = 1'b0;
  logic              we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              irq, sys_rst;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lp_watchdog i_lp_watchdog (
    .clk_i(clk), .rst_ni(rst_n), .lowpwr_i(lowpwr), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .sys_rst_o(sys_rst)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output int v);
    addr = a; #1; v = int'(rdata);
  endtask

  task automatic unlock();
    wr(A_LOCK, KEY_FIRST);
    wr(A_LOCK, KEY_SECOND);
  endtask

  task automatic cfg(int ign, int mat);
    wr(A_CTRL, 16'h0002);
    wr(A_IGN, DATA_W'(ign));
    wr(A_MATCH, DATA_W'(mat));
    wr(A_IRQ, 16'h0001);
    wr(A_CTRL, 16'h0008);
    wr(A_CTRL, 16'h0008);
    wr(A_CTRL, 16'h0001);
  endtask

  task automatic wait_rst(int limit, output int n);
    n = 0;
    for (int i = 1; i <= limit && n == 0; i++) begin
      @(negedge clk);
      if (sys_rst) n = i;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int v, n, c0, c1, first, pulses;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(A_CNT, v);  check("R1 reset count", v, 0);
    rd(A_CTRL, v); check("R1 reset enable", v, 0);
    rd(A_LOCK, v); check("R7 reset locked", v, 0);
    check("R4 reset sys_rst", int'(sys_rst), 0);
    check("R8 reset irq", int'(irq), 0);

    // R7 locked writes ignored
    wr(A_CTRL, 16'h0001); rd(A_CTRL, v);  check("R7 locked enable", v, 0);
    wr(A_MATCH, 16'h0007); rd(A_MATCH, v); check("R7 locked match", v, 0);
    rd(A_CNT, v); check("R7 locked count held", v, 0);
    wr(A_LOCK, KEY_FIRST); wr(A_LOCK, 16'h1234);
    rd(A_LOCK, v); check("R7 wrong second key", v, 0);
    wr(A_LOCK, KEY_SECOND); rd(A_LOCK, v); check("R7 second key alone", v, 0);
    unlock(); rd(A_LOCK, v); check("R7 key pair opens", v, 1);
    wr(A_LOCK, 16'h0000); rd(A_LOCK, v); check("R7 other write shuts", v, 0);
    unlock();

    // R2 clamp
    wr(A_IGN, 16'd15); rd(A_IGN, v); check("R2 ignore clamp", v, 12);

    // vector table: R2 R4 R5
    for (int k = 0; k < VEC_N; k++) begin
      lowpwr = V_LP[k][0];
      cfg(V_IGN[k], V_MAT[k]);
      wait_rst(400, n);
      check(V_LP[k] != 0 ? "R5 lowpwr timeout" : "R4 R2 timeout", n, V_EXP[k]);
      @(negedge clk);
      check("R4 pulse width", int'(sys_rst), 0);
      check("R8 irq after match", int'(irq), 1);
    end
    lowpwr = 1'b0;

    // R8 mask and clear
    wr(A_IRQ, 16'h0003); lowpwr = 1'b1; cfg(12, 4);
    wr(A_IRQ, 16'h0002);
    wait_rst(100, n);
    check("R8 masked irq low", int'(irq), 0);
    rd(A_IRQ, v); check("R8 pending readable", v & 1, 1);
    wr(A_IRQ, 16'h0003); rd(A_IRQ, v); check("R8 clear pending", v & 1, 0);
    wr(A_IRQ, 16'h0000); lowpwr = 1'b0;

    // R1 counting and R9 late counter reset
    cfg(12, 5);
    repeat (7) @(negedge clk);
    rd(A_CNT, c0); @(negedge clk); rd(A_CNT, c1);
    check("R1 step", c1, c0 + 1);
    wr(A_CTRL, 16'h0008);
    rd(A_CNT, v); check("R9 stale read", v, c1 + 1);
    @(negedge clk); rd(A_CNT, v); check("R9 cleared", v, 0);

    // R6 periodic kick prevents reset
    cfg(12, 5);
    pulses = 0;
    for (int k = 0; k < 10; k++) begin
      for (int j = 0; j < 19; j++) begin
        @(negedge clk);
        if (sys_rst) pulses++;
      end
      wr(A_CTRL, 16'h0004);
      if (sys_rst) pulses++;
    end
    check("R6 kicked no reset", pulses, 0);
    wait_rst(60, n);
    check("R6 unkicked resets", int'(n > 0), 1);

    // R10 disable holds counter and clears escalation
    cfg(12, 5);
    repeat (24) @(negedge clk);
    wr(A_CTRL, 16'h0003);
    rd(A_CTRL, v); check("R10 disable wins", v, 0);
    rd(A_CNT, c0); repeat (3) @(negedge clk); rd(A_CNT, c1);
    check("R10 counter held", c1, c0);
    first = c0 - (c0 % 16) + 5;
    if (first <= c0) first += 16;
    wr(A_CTRL, 16'h0001);
    wait_rst(200, n);
    check("R10 fresh escalation", n, first + 32 - c0 + 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule